// File: doc/BRIEF.md
# Partitioned Carry-Break Adder

This block is a purely combinational 32-bit adder whose carry chain can be cut at run time. The datapath is made of four 8-bit sections. A 3-bit partition mask has one bit for each internal boundary between sections. A set bit stops the carry at that boundary. A clear bit lets the carry pass, so the neighbouring sections join into one wider sum. A single adder therefore gives one to four independent sums, 8, 16, 24 or 32 bits wide, in any arrangement the mask selects.

Inside, the two operands are widened to 35 bits. A spacer bit sits between each pair of sections. At a joined boundary the spacer is 1 in one operand and 0 in the other, so an incoming carry passes straight through it. At a split boundary both spacers are 0, so the carry is absorbed and shows up as that lane's carry-out. The spacer positions of the wide sum never reach the sum output.

Each lane reports its carry-out on a 4-bit vector, at the index of the lane's top section.

Top module: `partitioned_adder`

## Requirements
- R1: With mask 3'b111, each 8-bit section k (bits 8k+7..8k) of the sum equals the sum of the matching operand bytes modulo 256, and cout[k] is that byte sum's carry.
- R2: Mask bit i controls the boundary between section i and section i+1. Bit 0 is the boundary between sum bits 7 and 8, bit 1 between 15 and 16, and bit 2 between 23 and 24. A clear bit joins the two sections, and the carry ripples from the lower section into the upper one.
- R3: With mask 3'b000, {cout[3], sum} equals the full 33-bit result of a + b.
- R4: All eight mask values are legal. For every mask, each lane (a maximal run of sections joined by clear bits) gives the sum of its operand slices modulo 2^(lane width).
- R5: cout[k] is the carry-out of the lane whose top section is k. Section 3 is always a lane top, and section k<3 is a lane top exactly when mask[k]=1. Every other cout entry is 0.
- R6: No carry crosses a split boundary. Even with all-ones operands, the section above a set mask bit sees a carry-in of 0. The carry-in of section 0 is always 0.
- R7: The block holds no state. sum and cout depend only on the present values of a, b and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| mask | input | 3 | Partition mask; bit i set splits section i from section i+1 |
| sum | output | 32 | Lane sums packed in place |
| cout | output | 4 | Per-lane carry-out at each lane's top-section index |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench drives a, b and mask on the falling clock edge and samples sum and cout a few nanoseconds later, before the next rising edge. Each check therefore sees only the settled result of the vector just applied. Expected values come from slicing the operands by lane in bench arithmetic.

// File: rtl/padd_pkg.sv
package padd_pkg;
  localparam int unsigned SEC_W    = 8;
  localparam int unsigned NUM_SEC  = 4;
  localparam int unsigned DATA_W   = SEC_W * NUM_SEC;
  localparam int unsigned NUM_BRK  = NUM_SEC - 1;
  localparam int unsigned WIDE_W   = DATA_W + NUM_BRK;
  localparam int unsigned STRIDE   = SEC_W + 1;

  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [WIDE_W-1:0]  wide_t;
  typedef logic [NUM_BRK-1:0] brk_t;
  typedef logic [NUM_SEC-1:0] lane_t;
endpackage

// File: rtl/padd_spread.sv
module padd_spread
  import padd_pkg::*;
(
  input  data_t a_i,
  input  data_t b_i,
  input  brk_t  brk_i,
  output wide_t a_wide_o,
  output wide_t b_wide_o
);
  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    assign a_wide_o[s*STRIDE +: SEC_W] = a_i[s*SEC_W +: SEC_W];
    assign b_wide_o[s*STRIDE +: SEC_W] = b_i[s*SEC_W +: SEC_W];
    if (s < NUM_SEC - 1) begin : g_gap
      // joined: 1+0 passes carry; split: 0+0 absorbs it
      assign a_wide_o[s*STRIDE + SEC_W] = ~brk_i[s];
      assign b_wide_o[s*STRIDE + SEC_W] = 1'b0;
    end
  end
endmodule

// File: rtl/padd_wide_add.sv
module padd_wide_add
  import padd_pkg::*;
(
  input  wide_t            x_i,
  input  wide_t            y_i,
  output logic [WIDE_W:0]  z_o
);
  always_comb begin
    z_o = {1'b0, x_i} + {1'b0, y_i};
  end
endmodule

// File: rtl/padd_gather.sv
module padd_gather
  import padd_pkg::*;
(
  input  logic [WIDE_W:0] z_i,
  input  brk_t            brk_i,
  output data_t           sum_o,
  output lane_t           cout_o
);
  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    assign sum_o[s*SEC_W +: SEC_W] = z_i[s*STRIDE +: SEC_W];
    if (s < NUM_SEC - 1) begin : g_mid
      // at a split gap the sum bit holds the section's carry
      assign cout_o[s] = brk_i[s] & z_i[s*STRIDE + SEC_W];
    end else begin : g_top
      assign cout_o[s] = z_i[WIDE_W];
    end
  end
endmodule

// File: rtl/partitioned_adder.sv
module partitioned_adder
  import padd_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [2:0]  mask,
  output logic [31:0] sum,
  output logic [3:0]  cout
);
  wide_t           a_wide;
  wide_t           b_wide;
  logic [WIDE_W:0] z_wide;

  padd_spread u_spread (
    .a_i      (a),
    .b_i      (b),
    .brk_i    (mask),
    .a_wide_o (a_wide),
    .b_wide_o (b_wide)
  );

  padd_wide_add u_add (
    .x_i (a_wide),
    .y_i (b_wide),
    .z_o (z_wide)
  );

  padd_gather u_gather (
    .z_i    (z_wide),
    .brk_i  (mask),
    .sum_o  (sum),
    .cout_o (cout)
  );

  logic [32:0] chk_full;
  logic [8:0]  chk_low;
  logic [7:0]  chk_top;
  always_comb begin
    chk_full = {1'b0, a} + {1'b0, b};
    chk_low  = {1'b0, a[7:0]} + {1'b0, b[7:0]};
    chk_top  = a[31:24] + b[31:24];
    // R5: carries appear only at lane tops
    a_r5_cout_at_tops: assert ((cout & ~{1'b1, mask}) == 4'b0000)
      else $error("cout outside lane top");
    // R3: fully joined equals 33-bit add
    if (mask == 3'b000) begin
      a_r3_full_join: assert ({cout[3], sum} == chk_full)
        else $error("joined sum mismatch");
    end
    // R1: isolated bottom section
    if (mask[0]) begin
      a_r1_low_isolated: assert ({cout[0], sum[7:0]} == chk_low)
        else $error("low section mismatch");
    end
    // R6: no carry enters the top section across a split
    if (mask[2]) begin
      a_r6_top_blocked: assert (sum[31:24] == chk_top)
        else $error("carry leaked into top section");
    end
  end
endmodule

// File: tb/partitioned_adder_tb.sv
module partitioned_adder_tb;
  logic        clk;
  logic [31:0] a, b;
  logic [2:0]  mask;
  logic [31:0] sum;
  logic [3:0]  cout;
  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  partitioned_adder u_dut (
    .a    (a),
    .b    (b),
    .mask (mask),
    .sum  (sum),
    .cout (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model(input logic [31:0] x, input logic [31:0] y,
                       input logic [2:0] m,
                       output logic [31:0] es, output logic [3:0] ec);
    int lo;
    es = '0;
    ec = '0;
    lo = 0;
    for (int s = 0; s < 4; s++) begin
      if (s == 3 || m[s]) begin
        logic [32:0] xs, ys, r;
        int w;
        w  = 8 * (s - lo + 1);
        xs = 33'((x >> (8 * lo)) & ((33'd1 << w) - 1));
        ys = 33'((y >> (8 * lo)) & ((33'd1 << w) - 1));
        r  = xs + ys;
        for (int k = 0; k < w; k++) es[8 * lo + k] = r[k];
        ec[s] = r[w];
        lo = s + 1;
      end
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y,
                       input logic [2:0] m, input string tag);
    logic [31:0] es;
    logic [3:0]  ec;
    @(negedge clk);
    a = x; b = y; mask = m;
    #2;
    model(x, y, m, es, ec);
    n_vec++;
    if (sum !== es || cout !== ec) begin
      n_bad++;
      $display("FAIL %s mask=%b a=%h b=%h sum=%h/%h exp=%h/%h",
               tag, m, x, y, sum, cout, es, ec);
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    a = '0; b = '0; mask = '0;
    // R7: zero inputs give zero outputs, no state involved
    apply(32'h0, 32'h0, 3'b000, "R7 idle");
    // R3: full-width joined add
    apply(32'hFFFF_FFFF, 32'h1, 3'b000, "R3 wrap");
    apply(32'h8000_0000, 32'h8000_0000, 3'b000, "R3 carry");
    // R1: four isolated bytes
    apply(32'hFF80_7F01, 32'h0180_81FF, 3'b111, "R1 bytes");
    // R2: boundary position per mask bit
    apply(32'h0000_00FF, 32'h1, 3'b110, "R2 bit0 joins");
    apply(32'h0000_FFFF, 32'h1, 3'b101, "R2 bit1 joins");
    apply(32'h00FF_FFFF, 32'h1, 3'b011, "R2 bit2 joins");
    for (int m = 0; m < 8; m++) begin
      // R6: all-ones stress at every break
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'(m), "R6 ones");
      apply(32'hFFFF_FFFF, 32'h0000_0001, 3'(m), "R6 ripple");
      // R5: carry location per lane
      apply(32'h8080_8080, 32'h8080_8080, 3'(m), "R5 tops");
      for (int i = 0; i < 150; i++) begin
        apply($urandom, $urandom, 3'(m), "R4 random");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog expired got=hang exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule